// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave

This block is a two-wire serial slave (SMBus / I2C bit timing, no clock stretching) that lets a host reach a small bank of 8-bit configuration registers through block transfers that carry an explicit index and byte count. The block takes already-synchronized SCL and SDA levels. It pulls SDA low through an active-high output-enable, and a board pull-up provides the high level.

To write, the host addresses the device with the write address byte. It then sends a register index, a byte count and the data bytes, and the data bytes land in consecutive registers. To read, the host first sets the index with a write address phase. It then issues a repeated START and the read address byte, and the slave returns the stored byte count followed by register contents from the selected index onward until the host declines a byte. A parallel port gives on-chip logic direct access to the same registers.

Top module: `smb_blk_slave`

## Requirements
- R1: Only the address bytes 0xDC (write) and 0xDD (read), that is the 7-bit address 0x6E, are ACKed. Any other address byte is NACKed, and the slave then keeps SDA released and ignores all bytes, even a later 0xDC, until the next START.
- R2: In a write, the slave ACKs the address, the index byte, the count byte and every data byte. The first data byte is stored at the index and each further byte at the next index.
- R3: Only the low 4 bits of the index byte are used. The index advances after every data byte that is written and after every register byte that is read, and it wraps from 15 to 0.
- R4: The count byte of a write is stored in a count register whose reset value is 8. The first byte a read returns is that register's value.
- R5: After the read address is ACKed, the slave sends the count byte and then the registers from the current index onward, MSB first. Each ACK from the host makes the slave send the next register.
- R6: After a host NACK, the slave keeps SDA released (the host reads 0xFF) until a STOP or a START.
- R7: A write may carry more data bytes than its count. Every byte is ACKed and stored with index wrap, and the count affects only what a read reports.
- R8: The slave changes SDA only while SCL is low, never while SCL is high.
- R9: A STOP or a START at any point releases SDA and ends the current transfer. A START begins a new address phase, and data already stored is kept.
- R10: A parallel write stores reg_wr_data_i at reg_wr_idx_i and is then visible to host reads. reg_rd_data_o always shows the register at reg_rd_idx_i, including bytes written by the host.
- R11: After reset all registers are 0, the count register is 8, the index is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level (wired line) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en_i | input | 1 | Parallel register write strobe |
| reg_wr_idx_i | input | 4 | Parallel write register index |
| reg_wr_data_i | input | 8 | Parallel write data |
| reg_rd_idx_i | input | 4 | Parallel read register index |
| reg_rd_data_o | output | 8 | Register contents at reg_rd_idx_i |

## Verification
The bench targets several corner cases:
- Index wrap at the end of the bank, on both writes and reads. A design that clamped the index or ran past it would store into or return the wrong registers.
- Writes that send more bytes than their count. A design that stopped ACKing at the count would make the host see a NACK too early.
- An index byte with its high bits set. A design that used those bits would hit no register.
- A foreign address followed by a good address byte with no START between them. A design that matched the second byte anyway would ACK it.
- The bus after a host NACK, and transfers cut short by a STOP or a repeated START. A design that kept driving SDA would corrupt the bytes the host reads or leave a stale byte phase behind.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  localparam int          DW       = 8;
  localparam logic [6:0]  DEV_ADDR = 7'h6E;
  localparam logic [7:0]  CNT_RST  = 8'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } kind_e;
endpackage

// File: rtl/smb_blk_cond.sv
module smb_blk_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // data edges with SCL held high are bus conditions
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/smb_blk_regs.sv
module smb_blk_regs #(
  parameter int NREG  = 16,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             h_we_i,
  input  logic [IDX_W-1:0] h_widx_i,
  input  logic [DW-1:0]    h_wdata_i,
  input  logic [IDX_W-1:0] h_ridx_i,
  output logic [DW-1:0]    h_rdata_o,
  input  logic             p_we_i,
  input  logic [IDX_W-1:0] p_widx_i,
  input  logic [DW-1:0]    p_wdata_i,
  input  logic [IDX_W-1:0] p_ridx_i,
  output logic [DW-1:0]    p_rdata_o
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[g] <= '0;
      end else if (h_we_i && h_widx_i == IDX_W'(g)) begin
        mem[g] <= h_wdata_i;   // serial host wins a same-cycle clash
      end else if (p_we_i && p_widx_i == IDX_W'(g)) begin
        mem[g] <= p_wdata_i;
      end
    end
  end

  assign h_rdata_o = mem[h_ridx_i];
  assign p_rdata_o = mem[p_ridx_i];
endmodule

// File: rtl/smb_blk_fsm.sv
module smb_blk_fsm
  import smb_blk_pkg::*;
#(
  parameter int         IDX_W   = 4,
  parameter logic [6:0] ADDR7   = DEV_ADDR,
  parameter logic [7:0] CNT_INI = CNT_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [DW-1:0]    wdata_o,
  output logic             sda_oe_o
);
  st_e              st;
  kind_e            kind;
  logic [DW-1:0]    sr;
  logic [3:0]       bcnt;
  logic [IDX_W-1:0] ptr;
  logic [DW-1:0]    cnt_reg;
  logic             tx_go;
  logic             ack_ok;
  logic             oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      kind    <= K_ADDR;
      sr      <= '0;
      bcnt    <= '0;
      ptr     <= '0;
      cnt_reg <= CNT_INI;
      tx_go   <= 1'b0;
      ack_ok  <= 1'b0;
      oe      <= 1'b0;
      we_o    <= 1'b0;
      widx_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (stop_i) begin
        st     <= ST_IDLE;
        oe     <= 1'b0;
        ack_ok <= 1'b0;
      end else if (start_i) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        bcnt   <= '0;
        oe     <= 1'b0;
        ack_ok <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise_i && bcnt != 4'd8) begin
              sr   <= {sr[DW-2:0], sda_i};
              bcnt <= bcnt + 4'd1;
            end
            if (scl_fall_i && bcnt == 4'd8) begin
              unique case (kind)
                K_ADDR: begin
                  if (sr[7:1] == ADDR7) begin
                    oe <= 1'b1;
                    st <= ST_RX_ACK;
                    if (sr[0]) begin
                      tx_go <= 1'b1;
                      sr    <= cnt_reg;
                    end else begin
                      tx_go <= 1'b0;
                      kind  <= K_INDEX;
                    end
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                K_INDEX: begin
                  ptr   <= sr[IDX_W-1:0];
                  kind  <= K_COUNT;
                  tx_go <= 1'b0;
                  oe    <= 1'b1;
                  st    <= ST_RX_ACK;
                end
                K_COUNT: begin
                  cnt_reg <= sr;
                  kind    <= K_DATA;
                  tx_go   <= 1'b0;
                  oe      <= 1'b1;
                  st      <= ST_RX_ACK;
                end
                default: begin
                  we_o    <= 1'b1;
                  widx_o  <= ptr;
                  wdata_o <= sr;
                  ptr     <= ptr + 1'b1;
                  tx_go   <= 1'b0;
                  oe      <= 1'b1;
                  st      <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              bcnt <= '0;
              if (tx_go) begin
                oe <= !sr[DW-1];
                sr <= {sr[DW-2:0], 1'b0};
                st <= ST_TX;
              end else begin
                oe <= 1'b0;
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) bcnt <= bcnt + 4'd1;
            if (scl_fall_i) begin
              if (bcnt == 4'd8) begin
                oe <= 1'b0;
                st <= ST_TX_ACK;
              end else begin
                oe <= !sr[DW-1];
                sr <= {sr[DW-2:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              if (!sda_i) begin
                sr     <= rd_data_i;
                ptr    <= ptr + 1'b1;
                ack_ok <= 1'b1;
              end else begin
                st <= ST_WAIT;   // host NACK: bus stays released
              end
            end
            if (scl_fall_i && ack_ok) begin
              ack_ok <= 1'b0;
              bcnt   <= '0;
              oe     <= !sr[DW-1];
              sr     <= {sr[DW-2:0], 1'b0};
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx_o = ptr;
  assign sda_oe_o = oe;
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
  import smb_blk_pkg::*;
#(
  parameter int         NREG    = 16,
  parameter logic [6:0] ADDR7   = DEV_ADDR,
  parameter logic [7:0] CNT_INI = CNT_RST,
  localparam int        IDX_W   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             reg_wr_en_i,
  input  logic [IDX_W-1:0] reg_wr_idx_i,
  input  logic [DW-1:0]    reg_wr_data_i,
  input  logic [IDX_W-1:0] reg_rd_idx_i,
  output logic [DW-1:0]    reg_rd_data_o
);
  logic             scl_rise_w, scl_fall_w, start_w, stop_w;
  logic             host_we_w;
  logic [IDX_W-1:0] host_widx_w, host_ridx_w;
  logic [DW-1:0]    host_wdata_w, host_rdata_w;

  smb_blk_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  smb_blk_fsm #(
    .IDX_W   (IDX_W),
    .ADDR7   (ADDR7),
    .CNT_INI (CNT_INI)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .sda_i      (sda_i),
    .rd_data_i  (host_rdata_w),
    .rd_idx_o   (host_ridx_w),
    .we_o       (host_we_w),
    .widx_o     (host_widx_w),
    .wdata_o    (host_wdata_w),
    .sda_oe_o   (sda_oe_o)
  );

  smb_blk_regs #(
    .NREG  (NREG),
    .DW    (DW),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_we_i    (host_we_w),
    .h_widx_i  (host_widx_w),
    .h_wdata_i (host_wdata_w),
    .h_ridx_i  (host_ridx_w),
    .h_rdata_o (host_rdata_w),
    .p_we_i    (reg_wr_en_i),
    .p_widx_i  (reg_wr_idx_i),
    .p_wdata_i (reg_wr_data_i),
    .p_ridx_i  (reg_rd_idx_i),
    .p_rdata_o (reg_rd_data_o)
  );
endmodule

// File: rtl/smb_blk_chk.sv
module smb_blk_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             start_w,
  input logic             stop_w,
  input logic             reg_wr_en_i,
  input logic [IDX_W-1:0] reg_wr_idx_i,
  input logic [7:0]       reg_wr_data_i,
  input logic [IDX_W-1:0] reg_rd_idx_i,
  input logic [7:0]       reg_rd_data_o,
  input logic             host_we_w,
  input logic [IDX_W-1:0] host_widx_w,
  input logic [7:0]       host_wdata_w
);
  a_r8_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  a_r9_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  a_r9_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);

  a_r2_host_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_w |=> (reg_rd_idx_i != $past(host_widx_w)) ||
                  (reg_rd_data_o == $past(host_wdata_w)));

  a_r10_par_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_en_i && !(host_we_w && host_widx_w == reg_wr_idx_i)) |=>
      (reg_rd_idx_i != $past(reg_wr_idx_i)) ||
      (reg_rd_data_o == $past(reg_wr_data_i)));
endmodule

bind smb_blk_slave smb_blk_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scl_i         (scl_i),
  .sda_oe_o      (sda_oe_o),
  .start_w       (start_w),
  .stop_w        (stop_w),
  .reg_wr_en_i   (reg_wr_en_i),
  .reg_wr_idx_i  (reg_wr_idx_i),
  .reg_wr_data_i (reg_wr_data_i),
  .reg_rd_idx_i  (reg_rd_idx_i),
  .reg_rd_data_o (reg_rd_data_o),
  .host_we_w     (host_we_w),
  .host_widx_w   (host_widx_w),
  .host_wdata_w  (host_wdata_w)
);

// File: tb/smb_blk_slave_bench.sv
`timescale 1ns/1ps
module smb_blk_slave_bench;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic       p_we = 1'b0;
  logic [3:0] p_widx = '0;
  logic [7:0] p_wdata = '0;
  logic [3:0] p_ridx = '0;
  logic [7:0] p_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_h & ~sda_oe;

  smb_blk_slave u_smb_blk_slave (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .scl_i         (scl_h),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .reg_wr_en_i   (p_we),
    .reg_wr_idx_i  (p_widx),
    .reg_wr_data_i (p_wdata),
    .reg_rd_idx_i  (p_ridx),
    .reg_rd_data_o (p_rdata)
  );

  // R8 monitor: output-enable must not move while SCL stays high
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_prev && scl_h && sda_oe != oe_prev) viol++;
    scl_prev <= scl_h;
    oe_prev  <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic smp);
    sda_h = b;
    tick(Q);
    scl_h = 1'b1;
    tick(Q);
    smp = sda_line;
    scl_h = 1'b0;
    tick(2);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(nack, s);
  endtask

  task automatic par_rd(input logic [3:0] idx, output logic [7:0] d);
    p_ridx = idx;
    tick(1);
    d = p_rdata;
  endtask

  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  // write: index n, count x, nb data bytes from wbuf; returns ack count
  task automatic blk_write(input logic [7:0] n, input logic [7:0] x, input int nb, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte(8'hDC, a); acks += int'(a);
    send_byte(n, a);     acks += int'(a);
    send_byte(x, a);     acks += int'(a);
    for (int i = 0; i < nb; i++) begin
      send_byte(wbuf[i], a); acks += int'(a);
    end
    bus_stop();
  endtask

  task automatic blk_read_open(input logic [7:0] n, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte(8'hDC, a); acks += int'(a);
    send_byte(n, a);     acks += int'(a);
    bus_rstart();
    send_byte(8'hDD, a); acks += int'(a);
  endtask

  task automatic blk_read(input logic [7:0] n, input int nb, output logic [7:0] cnt, output int acks);
    blk_read_open(n, acks);
    recv_byte(nb == 0, cnt);
    for (int i = 0; i < nb; i++) recv_byte(i == nb - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d, c;
    int a;
    check("R11 oe released after reset", {7'd0, sda_oe}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      par_rd(4'(i), d);
      check($sformatf("R11 reg%0d reset", i), d, 8'h00);
    end
    blk_read(8'h00, 0, c, a);
    check("R4 reset count value", c, 8'd8);
    check("R1 read addresses acked", 8'(a), 8'd3);
  endtask

  task automatic t_write();
    logic [7:0] d;
    int a;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    blk_write(8'h03, 8'h04, 4, a);
    check("R2 write acks", 8'(a), 8'd7);
    for (int i = 0; i < 4; i++) begin
      par_rd(4'(3 + i), d);
      check($sformatf("R2 reg%0d written", 3 + i), d, wbuf[i]);
    end
    par_rd(4'd7, d);
    check("R2 reg7 untouched", d, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] c, x;
    int a;
    blk_read_open(8'h03, a);
    check("R1 read open acks", 8'(a), 8'd3);
    recv_byte(1'b0, c);
    check("R4 count byte first", c, 8'd4);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, x);
      check($sformatf("R5 read byte %0d", i), x, 8'h11 * 8'(i + 1));
    end
    recv_byte(1'b1, x);
    check("R6 released after nack", x, 8'hFF);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic [7:0] d, c;
    int a;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    blk_write(8'h0E, 8'h02, 4, a);
    check("R7 over-length write all acked", 8'(a), 8'd7);
    par_rd(4'd14, d); check("R7 reg14", d, 8'hA1);
    par_rd(4'd15, d); check("R7 reg15", d, 8'hA2);
    par_rd(4'd0, d);  check("R3 wrap reg0", d, 8'hA3);
    par_rd(4'd1, d);  check("R3 wrap reg1", d, 8'hA4);
    blk_read(8'h0F, 3, c, a);
    check("R7 count only reports", c, 8'd2);
    check("R3 read reg15", rbuf[0], 8'hA2);
    check("R3 read wraps reg0", rbuf[1], 8'hA3);
    check("R3 read wraps reg1", rbuf[2], 8'hA4);
  endtask

  task automatic t_idx_hi();
    logic [7:0] d;
    int a;
    wbuf[0] = 8'h5A;
    blk_write(8'h25, 8'h01, 1, a);
    par_rd(4'd5, d);
    check("R3 high index bits dropped", d, 8'h5A);
  endtask

  task automatic t_bad_addr();
    logic a1, a2;
    logic [7:0] x;
    int v0;
    v0 = viol;
    bus_start();
    send_byte(8'hA0, a1);
    check("R1 foreign address nacked", {7'd0, a1}, 8'h00);
    send_byte(8'hDC, a2);
    check("R1 ignored until START", {7'd0, a2}, 8'h00);
    recv_byte(1'b1, x);
    check("R1 bus stays released", x, 8'hFF);
    bus_stop();
    check("R1 no drive during foreign", 8'(viol - v0), 8'd0);
  endtask

  task automatic t_par();
    logic [7:0] c;
    int a;
    p_widx = 4'd9; p_wdata = 8'h77; p_we = 1'b1;
    tick(1);
    p_we = 1'b0;
    tick(1);
    blk_read(8'h09, 1, c, a);
    check("R10 count still 1", c, 8'd1);
    check("R10 parallel write seen by host", rbuf[0], 8'h77);
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d, c;
    int ac;
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h02, a);
    bus_stop();
    check("R9 oe off after stop", {7'd0, sda_oe}, 8'h00);
    bus_start();
    send_byte(8'hDC, a);
    send_byte(8'h00, a);
    send_byte(8'h05, a);
    send_byte(8'h01, a);
    bus_rstart();
    send_byte(8'hDC, a);
    check("R9 restart address acked", {7'd0, a}, 8'h01);
    send_byte(8'h08, a);
    send_byte(8'h01, a);
    send_byte(8'h88, a);
    bus_stop();
    par_rd(4'd0, d); check("R9 data before restart kept", d, 8'h01);
    par_rd(4'd8, d); check("R9 data after restart", d, 8'h88);
    par_rd(4'd2, d); check("R9 aborted write left reg2", d, 8'h00);
    blk_read(8'h08, 1, c, ac);
    check("R9 count from second write", c, 8'd1);
    check("R9 readback reg8", rbuf[0], 8'h88);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write();
    t_read();
    t_wrap();
    t_idx_hi();
    t_bad_addr();
    t_par();
    t_abort();
    check("R8 SDA only moves with SCL low", 8'(viol), 8'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule